// File: doc/BRIEF.md
# Digit-Serial Decimal Adder

This block adds two packed decimal numbers one digit at a time. Each clock cycle it can accept one 4-bit digit from each operand, starting with the least significant digit. A carry register passes the decimal carry from one digit to the next. The running sum comes out one digit per cycle. The block works in one of two digit codes. In plain 8421 BCD, a digit is its own binary value. In excess-3, a digit is stored as its value plus three. Both operands and the sum use the same code, and the adder applies the correction that the chosen code needs.

An operation opens with a `start_i` pulse. That pulse clears the carry and the error flag, and it samples the code select. The digits then follow with `dig_valid_i` high. The final digit is flagged with `last_i`. The carry produced by that final digit is held on `carry_o` until the next start. Any operand digit that is not legal in the chosen code sets a sticky error flag.

Top module: `dsa_decimal_adder`

## Requirements
- R1: While `rst_n` is low at a clock edge, all outputs (`sum_o`, `sum_valid_o`, `carry_o`, `err_o`) become 0, and the code select returns to 8421.
- R2: Each digit pair accepted with `dig_valid_i` gives exactly one `sum_valid_o` pulse, in the cycle after acceptance. In a cycle with no accepted digit, `sum_valid_o` is low on the next cycle.
- R3: In 8421 mode (`mode_i`=0), when the binary sum of the two digits plus the carry-in is 9 or less, that sum is output unchanged and no carry goes to the next digit.
- R4: In 8421 mode, when that binary sum is 10 to 19 (this includes sums that overflow 4 bits), the output digit is the low 4 bits of the sum plus 6, and a carry of 1 goes to the next digit.
- R5: In excess-3 mode (`mode_i`=1), every digit is coded as its value plus 3. When the 4-bit sum of the two digits plus the carry-in produces no carry out of bit 3, the output is that sum minus 3, and no decimal carry goes on.
- R6: In excess-3 mode, when that sum does carry out of bit 3, the output is the low 4 bits plus 3, and a carry of 1 goes to the next digit.
- R7: A start pulse makes the carry-in of the next accepted digit 0. This includes a digit accepted in the same cycle as the start. The code select is sampled only during start; changes to `mode_i` at any other time have no effect.
- R8: `carry_o` shows the decimal carry out of the digit flagged `last_i`, in the same cycle as that digit's sum. It holds that value until a start with no digit clears it to 0.
- R9: An operand digit above 9 in 8421 mode, or outside 3 to 12 in excess-3 mode, sets `err_o` in the cycle after it is accepted. `err_o` then stays high through later legal digits.
- R10: A start pulse clears `err_o` on the next cycle, unless an illegal digit is accepted in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Opens an operation: clears the carry and the error flag, and samples `mode_i` |
| mode_i | input | 1 | Digit code: 0 for 8421 BCD, 1 for excess-3 |
| dig_valid_i | input | 1 | The digit pair on `dig_a_i`/`dig_b_i` is accepted in this cycle |
| dig_a_i | input | 4 | Operand A digit |
| dig_b_i | input | 4 | Operand B digit |
| last_i | input | 1 | The accepted digit is the most significant one |
| sum_o | output | 4 | Corrected sum digit, in the selected code |
| sum_valid_o | output | 1 | `sum_o` holds a new digit |
| carry_o | output | 1 | Final decimal carry of the operation |
| err_o | output | 1 | Sticky flag for an illegal operand digit |

## Verification
Every result is registered once. A digit accepted at one rising edge has its sum and valid pulse visible just after that edge. The final carry appears in that same cycle for the last digit, and the error flag rises in that same cycle for an illegal digit. The bench changes inputs on the falling edge and reads outputs 1 ns after the rising edge that accepts the digit. In the following cycle it confirms that the valid pulse has dropped, and that the final carry and the error flag still hold their values.

// File: rtl/dsa_pkg.sv
// Shared types and constants for the digit-serial decimal adder.
// Assumes 4-bit decimal digits; the numeric limits below are tied to that width.
package dsa_pkg;
    localparam int DIG_W = 4;

    typedef enum logic {
        CODE_BCD = 1'b0,
        CODE_XS3 = 1'b1
    } code_e;

    localparam logic [DIG_W-1:0] BCD_MAX  = 4'd9;
    localparam logic [DIG_W-1:0] BCD_FIX  = 4'd6;
    localparam logic [DIG_W-1:0] XS3_BIAS = 4'd3;
    localparam logic [DIG_W-1:0] XS3_MIN  = 4'd3;
    localparam logic [DIG_W-1:0] XS3_MAX  = 4'd12;
endpackage

// File: rtl/dsa_digit_legal.sv
// Legality test for one operand digit under the selected code.
// Purely combinational. Assumes mode is the code in effect for this digit.
module dsa_digit_legal
    import dsa_pkg::*;
#(
    parameter int W = DIG_W
) (
    input  code_e          mode,
    input  logic [W-1:0]   dig,
    output logic           ok
);
    // Compare the digit against the range allowed by the active code.
    always_comb begin
        if (mode == CODE_BCD) ok = (dig <= BCD_MAX);
        else                  ok = (dig >= XS3_MIN) && (dig <= XS3_MAX);
    end
endmodule

// File: rtl/dsa_digit_correct.sv
// One decimal digit position: binary add, then the correction the code needs.
// Purely combinational. Assumes both digits are coded in the given mode.
module dsa_digit_correct
    import dsa_pkg::*;
#(
    parameter int W = DIG_W
) (
    input  code_e          mode,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic           cin,
    output logic [W-1:0]   sum,
    output logic           cout
);
    localparam int RW = W + 1;

    logic [RW-1:0] raw;

    // Raw binary sum, one bit wider to keep the carry out of the digit.
    assign raw = {1'b0, a} + {1'b0, b} + {{(RW-1){1'b0}}, cin};

    // Pick the correction from the code and the binary carry.
    always_comb begin
        if (mode == CODE_BCD) begin
            cout = raw > RW'(BCD_MAX);
            sum  = cout ? (raw[W-1:0] + BCD_FIX) : raw[W-1:0];
        end else begin
            cout = raw[W];
            sum  = cout ? (raw[W-1:0] + XS3_BIAS) : (raw[W-1:0] - XS3_BIAS);
        end
    end
endmodule

// File: rtl/dsa_out_stage.sv
// Output register for the sum digit and its one-cycle valid pulse.
// Assumes the top feeds it a digit and strobe from the same cycle.
module dsa_out_stage #(
    parameter int W = dsa_pkg::DIG_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           vld_d,
    input  logic [W-1:0]   sum_d,
    output logic           vld_q,
    output logic [W-1:0]   sum_q
);
    // Register the strobe every cycle; load the digit only with a new one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
            sum_q <= '0;
        end else begin
            vld_q <= vld_d;
            if (vld_d) sum_q <= sum_d;
        end
    end

    // R2: the valid pulse lasts one cycle for each accepted digit
    p_pulse_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        vld_d |=> vld_q);
    p_pulse_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_d |=> !vld_q);
endmodule

// File: rtl/dsa_decimal_adder.sv
// Digit-serial decimal adder, least significant digit first, in 8421 or excess-3.
// Assumes an operation opens with start_i and that its last digit is flagged with last_i.
module dsa_decimal_adder
    import dsa_pkg::*;
#(
    parameter int W     = DIG_W,
    parameter int N_OPS = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic           mode_i,
    input  logic           dig_valid_i,
    input  logic [W-1:0]   dig_a_i,
    input  logic [W-1:0]   dig_b_i,
    input  logic           last_i,
    output logic [W-1:0]   sum_o,
    output logic           sum_valid_o,
    output logic           carry_o,
    output logic           err_o
);
    code_e            mode_q;
    code_e            mode_eff;
    logic             carry_q;
    logic             cin_eff;
    logic [N_OPS-1:0] ok;
    logic [W-1:0]     ops [N_OPS];
    logic             illegal;
    logic [W-1:0]     sum_d;
    logic             cout_d;
    logic             fin_q;
    logic             err_q;

    assign ops[0] = dig_a_i;
    assign ops[1] = dig_b_i;

    // A digit taken in the start cycle already uses the new mode and a zero carry.
    assign mode_eff = start_i ? code_e'(mode_i) : mode_q;
    assign cin_eff  = start_i ? 1'b0 : carry_q;

    // One legality checker for each operand.
    for (genvar g = 0; g < N_OPS; g++) begin : g_legal
        dsa_digit_legal #(.W(W)) u_legal (
            .mode (mode_eff),
            .dig  (ops[g]),
            .ok   (ok[g])
        );
    end

    assign illegal = dig_valid_i && !(&ok);

    dsa_digit_correct #(.W(W)) u_corr (
        .mode (mode_eff),
        .a    (dig_a_i),
        .b    (dig_b_i),
        .cin  (cin_eff),
        .sum  (sum_d),
        .cout (cout_d)
    );

    // Sample the code at start; pass the decimal carry between digits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= CODE_BCD;
            carry_q <= 1'b0;
        end else begin
            if (start_i) mode_q <= code_e'(mode_i);
            if (dig_valid_i)  carry_q <= cout_d;
            else if (start_i) carry_q <= 1'b0;
        end
    end

    // Hold the carry out of the last digit until the next operation starts.
    always_ff @(posedge clk) begin
        if (!rst_n)                     fin_q <= 1'b0;
        else if (dig_valid_i && last_i) fin_q <= cout_d;
        else if (start_i)               fin_q <= 1'b0;
    end

    // Sticky error flag, cleared at start unless the start digit is itself bad.
    always_ff @(posedge clk) begin
        if (!rst_n)       err_q <= 1'b0;
        else if (start_i) err_q <= illegal;
        else if (illegal) err_q <= 1'b1;
    end

    dsa_out_stage #(.W(W)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .vld_d (dig_valid_i),
        .sum_d (sum_d),
        .vld_q (sum_valid_o),
        .sum_q (sum_o)
    );

    assign carry_o = fin_q;
    assign err_o   = err_q;

    // R4: with legal operands, an 8421 result is never above nine
    p_bcd_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sum_valid_o && mode_q == CODE_BCD && !err_o) |-> (sum_o <= BCD_MAX));
    // R6: with legal operands, an excess-3 result stays in its legal band
    p_xs3_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sum_valid_o && mode_q == CODE_XS3 && !err_o) |-> (sum_o >= XS3_MIN && sum_o <= XS3_MAX));
    // R9: the error flag is sticky between starts
    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !start_i) |=> err_o);
    // R10 and R8: a start with no digit clears both the error flag and the final carry
    p_start_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !dig_valid_i) |=> (!err_o && !carry_o));
    // R8: the final carry changes only at a last digit or at a start
    p_fin_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && !(dig_valid_i && last_i)) |=> $stable(carry_o));
endmodule

// File: tb/tb_dsa_decimal_adder.sv
`timescale 1ns/1ps
module tb_dsa_decimal_adder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       mode_i = 1'b0;
    logic       dig_valid_i = 1'b0;
    logic [3:0] dig_a_i = '0;
    logic [3:0] dig_b_i = '0;
    logic       last_i = 1'b0;
    logic [3:0] sum_o;
    logic       sum_valid_o;
    logic       carry_o;
    logic       err_o;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    always #2.5 clk = ~clk;

    dsa_decimal_adder dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
        .dig_valid_i(dig_valid_i), .dig_a_i(dig_a_i), .dig_b_i(dig_b_i),
        .last_i(last_i), .sum_o(sum_o), .sum_valid_o(sum_valid_o),
        .carry_o(carry_o), .err_o(err_o)
    );

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    // Start cycle with no digit.
    task automatic do_start(input bit m);
        @(negedge clk);
        start_i = 1'b1; mode_i = m; dig_valid_i = 1'b0; last_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // Full operation; a and b hold decimal digit values, one per nibble.
    task automatic run_op(input bit m, input logic [31:0] a, input logic [31:0] b,
                          input int n, input string rq);
        int c;
        c = 0;
        do_start(m);
        for (int i = 0; i < n; i++) begin
            int va, vb, s, ed;
            va = int'((a >> (4*i)) & 32'hF);
            vb = int'((b >> (4*i)) & 32'hF);
            dig_a_i = 4'(m ? va + 3 : va);
            dig_b_i = 4'(m ? vb + 3 : vb);
            dig_valid_i = 1'b1;
            last_i = (i == n-1);
            @(posedge clk); #1;
            s = va + vb + c; ed = s % 10; c = s / 10;
            if (m) ed = ed + 3;
            chk(sum_valid_o == 1'b1, {rq, " R2 valid"}, int'(sum_valid_o), 1);
            chk(int'(sum_o) == ed, {rq, " digit"}, int'(sum_o), ed);
            if (i == n-1) chk(int'(carry_o) == c, {rq, " R8 carry"}, int'(carry_o), c);
            @(negedge clk);
        end
        dig_valid_i = 1'b0; last_i = 1'b0;
        @(posedge clk); #1;
        chk(sum_valid_o == 1'b0, "R2 single pulse", int'(sum_valid_o), 0);
        chk(int'(carry_o) == c, "R8 carry held", int'(carry_o), c);
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk(sum_valid_o == 0 && carry_o == 0 && err_o == 0 && sum_o == 0, "R1 reset",
            int'({sum_o, sum_valid_o, carry_o, err_o}), 0);
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic test_bcd();
        run_op(1'b0, 32'h1234, 32'h4321, 4, "R3 plain");
        run_op(1'b0, 32'h0999, 32'h0001, 4, "R4 ripple");
        run_op(1'b0, 32'h99,   32'h99,   2, "R4 wide raw");
    endtask

    task automatic test_xs3();
        run_op(1'b1, 32'h1234, 32'h4321, 4, "R5 no carry");
        run_op(1'b1, 32'h0999, 32'h0001, 4, "R6 ripple");
        run_op(1'b1, 32'h58,   32'h67,   2, "R6 mixed");
    endtask

    // Start together with a digit after a carry was left; mode moved after start.
    task automatic test_start_carry();
        run_op(1'b0, 32'h9, 32'h9, 1, "R7 setup");
        @(negedge clk);
        start_i = 1'b1; mode_i = 1'b1; dig_valid_i = 1'b1;
        dig_a_i = 4'd4; dig_b_i = 4'd4; last_i = 1'b0;
        @(posedge clk); #1;
        chk(sum_o == 4'd5, "R7 start digit carry-in zero", int'(sum_o), 5);
        @(negedge clk);
        start_i = 1'b0; mode_i = 1'b0;
        dig_a_i = 4'd5; dig_b_i = 4'd5; last_i = 1'b1;
        @(posedge clk); #1;
        chk(sum_o == 4'd7, "R7 mode held after start", int'(sum_o), 7);
        chk(carry_o == 1'b0, "R8 new final carry", int'(carry_o), 0);
        chk(err_o == 1'b0, "R7 mode held, no error", int'(err_o), 0);
        @(negedge clk);
        dig_valid_i = 1'b0; last_i = 1'b0;
    endtask

    task automatic err_digit(input logic [3:0] a, input logic [3:0] b, input int exp, input string rq);
        @(negedge clk);
        dig_valid_i = 1'b1; dig_a_i = a; dig_b_i = b; last_i = 1'b0;
        @(posedge clk); #1;
        chk(int'(err_o) == exp, rq, int'(err_o), exp);
        @(negedge clk);
        dig_valid_i = 1'b0;
    endtask

    task automatic test_error();
        do_start(1'b0);
        err_digit(4'd10, 4'd0, 1, "R9 bcd above nine");
        err_digit(4'd1,  4'd2, 1, "R9 sticky");
        do_start(1'b0);
        #1;
        chk(err_o == 1'b0, "R10 cleared by start", int'(err_o), 0);
        err_digit(4'd9, 4'd9, 0, "R9 bcd nine legal");
        do_start(1'b1);
        err_digit(4'd3, 4'd2, 1, "R9 xs3 below three");
        do_start(1'b1);
        err_digit(4'd13, 4'd3, 1, "R9 xs3 above twelve");
        do_start(1'b1);
        err_digit(4'd3, 4'd12, 0, "R9 xs3 edges legal");
    endtask

    initial begin
        test_reset();
        test_bcd();
        test_xs3();
        test_start_carry();
        test_error();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule